// File: doc/BRIEF.md
# Two-Wire Register Target with Clock-Register Freeze

This block is a two-wire serial bus target that fronts a 64-byte register space. Its lowest eight bytes are a user-visible snapshot of a free-running timekeeping source. That source arrives as a parallel bus, and an update tick copies it into the snapshot. The remaining bytes are plain read/write storage. The serial clock and data lines enter as sampled inputs. The data line is driven through a separate pull-low enable, which models an open-drain pin. Both lines are oversampled by the block's system clock.

A controller selects the target with a 7-bit address chosen by parameter. In a write transfer, the first data byte sets an internal word pointer and any later bytes are stored. A read transfer returns bytes starting at the pointer. This gives random reads (set the pointer, repeated START, read), sequential reads and writes, and current-address reads. While an addressed transfer has the pointer inside the clock range, snapshot updates are held back. A controller therefore reads a consistent time. The hold is released by STOP, or when the pointer steps past the clock bytes.

Top module: `i2c_clkreg_target`

## Requirements
- R1: An address byte whose upper seven bits equal the parameter DEV_ADDR is acknowledged. Its least significant bit selects read (1) or write (0). The acknowledge is SDA pulled low during the ninth clock.
- R2: After an address byte that does not match, the target gives no acknowledge and keeps SDA released until the next START or STOP. The pointer is left unchanged.
- R3: In a write transfer, the first byte after the address is acknowledged. Its low six bits load the word pointer.
- R4: Each further write byte is acknowledged and stored at the pointer. The pointer advances by one on that acknowledge clock.
- R5: A random read returns the byte at the pointer, MSB first. A random read is a pointer write, then a repeated START, then the address with the read bit set.
- R6: During a read, each controller acknowledge advances the pointer, and the next byte comes from the new address. This continues until STOP.
- R7: A controller NACK ends data output and leaves the pointer unchanged. SDA stays released until START or STOP.
- R8: A read with no pointer write first starts at the address currently held in the pointer.
- R9: The pointer steps from 3Fh to 00h, both in reads and in writes.
- R10: When an update tick arrives and no hold is in force, all eight clock bytes are loaded from the live bus together. Byte k takes bits 8k+7..8k.
- R11: While an addressed transfer is in progress and the pointer is below 08h, update ticks leave the clock bytes unchanged.
- R12: The hold ends when a STOP arrives. It also ends when the pointer advances to 08h or above, even before STOP.
- R13: After reset, SDA is released, the pointer is 00h and every byte reads 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull-low enable for the data line |
| tick | input | 1 | Update strobe for the clock snapshot |
| live_time | input | 64 | Live time bytes, byte k in bits 8k+7..8k |

## Verification
The bench builds the block with its default parameters: device address 68h, 64 bytes and eight clock bytes, with a 6-bit pointer. With these values the pointer wrap from 3Fh to 00h is reachable within one short transfer. So is the clock-range boundary between 07h and 08h, where the hold must drop in the middle of a sequential read. The bench applies update ticks both inside and outside a held transfer. It compares the read-back bytes with the live values that were current at the last tick allowed through.

// File: rtl/i2c_clkreg_pkg.sv
package i2c_clkreg_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WORD,
        ST_WORD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_IGNORE
    } bus_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_evt_t;

    function automatic logic below_limit(input int unsigned a, input int unsigned lim);
        return a < lim;
    endfunction

endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler
    import i2c_clkreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);
    logic [SYNC_STAGES-1:0] scl_s, sda_s;
    logic scl_d, sda_d, scl_now, sda_now;

    assign scl_now = scl_s[SYNC_STAGES-1];
    assign sda_now = sda_s[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_s <= '1;
            sda_s <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_s <= {scl_s[SYNC_STAGES-2:0], scl_i};
            sda_s <= {sda_s[SYNC_STAGES-2:0], sda_i};
            scl_d <= scl_now;
            sda_d <= sda_now;
        end
    end

    always_comb begin
        evt.rise  = scl_now & ~scl_d;
        evt.fall  = ~scl_now & scl_d;
        evt.start = scl_now & scl_d & sda_d & ~sda_now;
        evt.stop  = scl_now & scl_d & ~sda_d & sda_now;
        evt.sda   = sda_now;
    end
endmodule

// File: rtl/i2c_xfer_fsm.sv
module i2c_xfer_fsm
    import i2c_clkreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR  = 7'h68,
    parameter int         MEM_BYTES = 64,
    parameter int         AW        = $clog2(MEM_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_evt_t      evt,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] ptr,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic          sda_oe,
    output logic          addressed
);
    localparam logic [AW-1:0] PTR_LAST = AW'(MEM_BYTES - 1);

    bus_state_e    st;
    logic [3:0]    bitcnt;
    logic [7:0]    sh, tx;
    logic          is_read, m_ack;
    logic [AW-1:0] ptr_inc;

    assign ptr_inc = (ptr == PTR_LAST) ? '0 : ptr + 1'b1;
    assign sda_oe  = (st == ST_ADDR_ACK) || (st == ST_WORD_ACK) || (st == ST_WDATA_ACK)
                  || (st == ST_RDATA && !tx[7]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            bitcnt    <= '0;
            sh        <= '0;
            tx        <= '0;
            is_read   <= 1'b0;
            m_ack     <= 1'b0;
            ptr       <= '0;
            wr_en     <= 1'b0;
            wr_data   <= '0;
            addressed <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (evt.stop) begin
                st        <= ST_IDLE;
                addressed <= 1'b0;
            end else if (evt.start) begin
                st     <= ST_ADDR;
                bitcnt <= '0;
            end else begin
                unique case (st)
                    ST_ADDR, ST_WORD, ST_WDATA: begin
                        if (evt.rise) begin
                            sh     <= {sh[6:0], evt.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (st == ST_ADDR) begin
                                if (sh[7:1] == DEV_ADDR) begin
                                    st        <= ST_ADDR_ACK;
                                    is_read   <= sh[0];
                                    addressed <= 1'b1;
                                end else begin
                                    st <= ST_IGNORE;
                                end
                            end else if (st == ST_WORD) begin
                                ptr <= sh[AW-1:0];
                                st  <= ST_WORD_ACK;
                            end else begin
                                wr_en   <= 1'b1;
                                wr_data <= sh;
                                st      <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: if (evt.fall) begin
                        if (is_read) begin
                            tx <= rd_data;
                            st <= ST_RDATA;
                        end else begin
                            st <= ST_WORD;
                        end
                    end
                    ST_WORD_ACK: if (evt.fall) st <= ST_WDATA;
                    ST_WDATA_ACK: begin
                        if (evt.rise) ptr <= ptr_inc;
                        else if (evt.fall) st <= ST_WDATA;
                    end
                    ST_RDATA: begin
                        if (evt.rise) begin
                            bitcnt <= bitcnt + 1'b1;
                        end else if (evt.fall) begin
                            if (bitcnt == 4'd8) begin
                                bitcnt <= '0;
                                st     <= ST_RACK;
                            end else begin
                                tx <= {tx[6:0], 1'b0};
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.rise) begin
                            if (!evt.sda) begin
                                ptr   <= ptr_inc;
                                m_ack <= 1'b1;
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end else if (evt.fall && m_ack) begin
                            m_ack <= 1'b0;
                            tx    <= rd_data;
                            st    <= ST_RDATA;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R4: outside a word-address load the pointer only ever steps by one
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(st) != ST_WORD && ptr != $past(ptr))
            |-> ptr == (($past(ptr) == PTR_LAST) ? '0 : $past(ptr) + 1'b1));

    // R9: a step from the last address lands on zero
    assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(ptr) == PTR_LAST && $past(st) != ST_WORD && ptr != $past(ptr))
            |-> ptr == '0);

    // R7: a controller NACK releases the line on the next cycle
    assert_nack_release_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RACK && evt.rise && evt.sda) |=> (!sda_oe && ptr == $past(ptr)));
endmodule

// File: rtl/i2c_clkreg_store.sv
module i2c_clkreg_store #(
    parameter int MEM_BYTES = 64,
    parameter int CLK_BYTES = 8,
    parameter int AW        = $clog2(MEM_BYTES)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic                   freeze,
    input  logic [CLK_BYTES*8-1:0] live_time,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [7:0]             wr_data,
    input  logic [AW-1:0]          rd_addr,
    output logic [7:0]             rd_data
);
    logic [MEM_BYTES-1:0][7:0] mem;
    logic                      copy_en;
    logic [CLK_BYTES*8-1:0]    clk_view;

    assign copy_en  = tick && !freeze;
    assign rd_data  = mem[rd_addr];
    assign clk_view = mem[CLK_BYTES-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else begin
            for (int i = 0; i < MEM_BYTES; i++) begin
                if (wr_en && wr_addr == AW'(i))
                    mem[i] <= wr_data;
                else if (i < CLK_BYTES && copy_en)
                    mem[i] <= live_time[8*i +: 8];
            end
        end
    end

    // R11: held snapshot does not move unless the bus writes it
    assert_hold_stable_R11: assert property (@(posedge clk) disable iff (rst)
        (freeze && !wr_en) |=> $stable(clk_view));

    // R10: an admitted tick loads all clock bytes at once
    assert_copy_whole_R10: assert property (@(posedge clk) disable iff (rst)
        (tick && !freeze && !wr_en) |=> clk_view == $past(live_time));
endmodule

// File: rtl/i2c_clkreg_target.sv
module i2c_clkreg_target
    import i2c_clkreg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h68,
    parameter int         MEM_BYTES   = 64,
    parameter int         CLK_BYTES   = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    input  logic                   tick,
    input  logic [CLK_BYTES*8-1:0] live_time
);
    localparam int AW = $clog2(MEM_BYTES);

    bus_evt_t      evt;
    logic [AW-1:0] ptr;
    logic          wr_en, addressed, freeze;
    logic [7:0]    wr_data, rd_data;

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .evt(evt)
    );

    i2c_xfer_fsm #(.DEV_ADDR(DEV_ADDR), .MEM_BYTES(MEM_BYTES), .AW(AW)) u_fsm (
        .clk(clk), .rst(rst), .evt(evt), .rd_data(rd_data), .ptr(ptr),
        .wr_en(wr_en), .wr_data(wr_data), .sda_oe(sda_oe), .addressed(addressed)
    );

    assign freeze = addressed && below_limit(int'(ptr), CLK_BYTES);

    i2c_clkreg_store #(.MEM_BYTES(MEM_BYTES), .CLK_BYTES(CLK_BYTES), .AW(AW)) u_store (
        .clk(clk), .rst(rst), .tick(tick), .freeze(freeze), .live_time(live_time),
        .wr_en(wr_en), .wr_addr(ptr), .wr_data(wr_data), .rd_addr(ptr), .rd_data(rd_data)
    );

    // R12: a STOP lifts the hold on the following cycle
    assert_thaw_on_stop_R12: assert property (@(posedge clk) disable iff (rst)
        evt.stop |=> !freeze);
endmodule

// File: tb/test_i2c_clkreg_target.sv
module test_i2c_clkreg_target;
    localparam logic [6:0] DEV = 7'h68;
    localparam int H = 16;
    localparam logic [13:0] RAM_VEC [6] = '{
        {6'h08, 8'hA5}, {6'h15, 8'h3C}, {6'h2A, 8'hF0},
        {6'h3F, 8'h81}, {6'h30, 8'h00}, {6'h1B, 8'hFF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1, tick = 1'b0;
    logic [63:0] live = '0;
    logic sda_oe, sda_bus;
    int checks = 0, errors = 0;
    bit finished = 1'b0;
    logic ack;
    logic [7:0] rb;
    logic [63:0] t1, t3, t4;

    assign sda_bus = sda_m & ~sda_oe;
    always #4 clk = ~clk;

    i2c_clkreg_target i_i2c_clkreg_target (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .tick(tick), .live_time(live)
    );

    task automatic hold(int n); repeat (n) @(negedge clk); endtask

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; hold(H); scl_m = 1'b1; hold(H);
        sda_m = 1'b0; hold(H); scl_m = 1'b0; hold(4);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; hold(H); scl_m = 1'b1; hold(H); sda_m = 1'b1; hold(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic a);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; hold(H); scl_m = 1'b1; hold(H); scl_m = 1'b0; hold(4);
        end
        sda_m = 1'b1; hold(H); scl_m = 1'b1; hold(H/2);
        a = !sda_bus;
        hold(H/2); scl_m = 1'b0; hold(4);
    endtask

    task automatic recv_byte(input logic mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hold(H); scl_m = 1'b1; hold(H/2); b[i] = sda_bus; hold(H/2);
            scl_m = 1'b0; hold(4);
        end
        sda_m = !mack; hold(H); scl_m = 1'b1; hold(H); scl_m = 1'b0; hold(4);
        sda_m = 1'b1;
    endtask

    task automatic put_byte(input logic [5:0] a, input logic [7:0] d);
        logic k;
        bus_start(); send_byte({DEV, 1'b0}, k); send_byte({2'b00, a}, k);
        send_byte(d, k); bus_stop();
    endtask

    task automatic get_byte(input logic [5:0] a, output logic [7:0] d);
        logic k;
        bus_start(); send_byte({DEV, 1'b0}, k); send_byte({2'b00, a}, k);
        bus_start(); send_byte({DEV, 1'b1}, k); recv_byte(1'b0, d); bus_stop();
    endtask

    task automatic pulse_tick(input logic [63:0] v);
        live = v; hold(1); tick = 1'b1; hold(1); tick = 1'b0; hold(2);
    endtask

    initial begin
        hold(5); rst = 1'b0; hold(5);
        chk("R13 sda released", {7'd0, sda_oe}, 8'h00);
        // R13 / R8: current-address read straight after reset
        bus_start(); send_byte({DEV, 1'b1}, ack); recv_byte(1'b0, rb); bus_stop();
        chk("R13 reset byte at pointer 00", rb, 8'h00);

        // R1, R3, R4, R5
        bus_start(); send_byte({DEV, 1'b0}, ack);
        chk("R1 address ack", {7'd0, ack}, 8'h01);
        send_byte(8'h20, ack);
        chk("R3 word address ack", {7'd0, ack}, 8'h01);
        send_byte(8'h5C, ack);
        chk("R4 data ack", {7'd0, ack}, 8'h01);
        bus_stop();
        get_byte(6'h20, rb);
        chk("R5 random read 20", rb, 8'h5C);

        // R2: foreign address
        bus_start(); send_byte({7'h11, 1'b0}, ack);
        chk("R2 no ack on foreign address", {7'd0, ack}, 8'h00);
        send_byte(8'h00, ack);
        chk("R2 line stays released", {7'd0, ack}, 8'h00);
        bus_stop();
        bus_start(); send_byte({DEV, 1'b1}, ack); recv_byte(1'b0, rb); bus_stop();
        chk("R2 pointer untouched", rb, 8'h5C);

        // table walk: R5 random write/read
        for (int k = 0; k < 6; k++) begin
            put_byte(RAM_VEC[k][13:8], RAM_VEC[k][7:0]);
            get_byte(RAM_VEC[k][13:8], rb);
            chk("R5 table read", rb, RAM_VEC[k][7:0]);
        end

        // R4 sequential write, R6 sequential read
        bus_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'h10, ack);
        send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
        chk("R4 third data ack", {7'd0, ack}, 8'h01);
        bus_stop();
        bus_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'h10, ack);
        bus_start(); send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b1, rb); chk("R6 seq byte 10", rb, 8'h11);
        recv_byte(1'b1, rb); chk("R6 seq byte 11", rb, 8'h22);
        recv_byte(1'b0, rb); chk("R6 seq byte 12", rb, 8'h33);
        bus_stop();

        // R7 / R8: NACK left pointer at 12
        bus_start(); send_byte({DEV, 1'b1}, ack); recv_byte(1'b0, rb);
        chk("R8 current read after NACK", rb, 8'h33);
        recv_byte(1'b0, rb);
        chk("R7 released after NACK", rb, 8'hFF);
        bus_stop();

        // R9 wrap in write and read
        bus_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'h3E, ack);
        send_byte(8'h77, ack); send_byte(8'h88, ack); send_byte(8'h99, ack);
        bus_stop();
        bus_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'h3F, ack);
        bus_start(); send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b1, rb); chk("R9 byte 3F", rb, 8'h88);
        recv_byte(1'b0, rb); chk("R9 wrapped to 00", rb, 8'h99);
        bus_stop();

        // R10: whole snapshot copied on an open tick
        t1 = 64'h8877_6655_4433_2211;
        pulse_tick(t1);
        bus_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'h00, ack);
        bus_start(); send_byte({DEV, 1'b1}, ack);
        for (int k = 0; k < 8; k++) begin
            recv_byte(k != 7, rb);
            chk("R10 clock byte", rb, t1[8*k +: 8]);
        end
        bus_stop();

        // R11 held while pointer in range; R12 released when pointer reaches 08
        bus_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'h02, ack);
        pulse_tick(64'h0102_0304_0506_0708);
        bus_start(); send_byte({DEV, 1'b1}, ack); recv_byte(1'b0, rb);
        chk("R11 held byte 02", rb, t1[23:16]);
        bus_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'h06, ack);
        bus_start(); send_byte({DEV, 1'b1}, ack);
        recv_byte(1'b1, rb); chk("R11 held byte 06", rb, t1[55:48]);
        recv_byte(1'b1, rb); chk("R11 held byte 07", rb, t1[63:56]);
        t3 = 64'hC7C6_C5C4_C3C2_C1C0;
        pulse_tick(t3);
        recv_byte(1'b0, rb); chk("R12 byte 08 during read", rb, 8'hA5);
        bus_stop();
        get_byte(6'h06, rb);
        chk("R12 update after pointer left range", rb, t3[55:48]);

        // R12: STOP releases the hold
        bus_start(); send_byte({DEV, 1'b0}, ack); send_byte(8'h03, ack); bus_stop();
        t4 = 64'hE7E6_E5E4_E3E2_E1E0;
        pulse_tick(t4);
        get_byte(6'h03, rb);
        chk("R12 update after STOP", rb, t4[31:24]);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule